// File: doc/BRIEF.md
# Flash Status Register and Write-Protection Guard

This block keeps the status byte of a serial NOR flash and rules on every request that would alter the array or the status byte. An upstream command decoder gives it one-cycle strobes for write-enable, write-disable, page program, sector erase, bulk erase and status write, together with the 24-bit target address and the status data byte. The guard answers each change request with a one-cycle grant or deny pulse. After a grant it reports busy until the array engine signals that the cycle has finished.

Protection has two layers. A three-bit protect level fences off a region of sectors at the top of the address space, and bulk erase is refused while any region is protected. A status-write lock bit, combined with the live level of an active-low write-protect pin, freezes the status byte. The freeze lasts only while the bit is set and the pin is held low. Every change request also needs the write-enable latch, and the latch is consumed whether the request wins or loses.

Top module: `flash_status_guard`

## Requirements
- R1: During and right after reset the status byte reads 0x00, and grant, deny and busy are all low.
- R2: The status byte is laid out as: bit 7 lock bit, bits 6:5 always zero, bits 4:2 protect level, bit 1 write-enable latch, bit 0 busy. A write-enable strobe sets bit 1 and a write-disable strobe clears it. When both strobes arrive in the same cycle, write-disable wins.
- R3: A program, erase or status-write request that arrives while the write-enable latch is clear is denied.
- R4: The sector number is address bits 23:17. Protect level 0 protects nothing, level 7 protects every sector, and a level n from 1 to 6 protects sectors 128-2^(n-1) through 127. A page program or sector erase aimed at a protected sector is denied, and one aimed elsewhere is granted when the latch is set.
- R5: A bulk erase is denied whenever the protect level is nonzero.
- R6: While the lock bit is 1 and the write-protect pin is low, a status write is denied and the status byte keeps its value. With the pin high, the same write is granted.
- R7: A granted status write loads bit 7 of the data byte into the lock bit and bits 4:2 into the protect level. Data bits 6:5 and 1:0 have no effect.
- R8: Grant or deny is a single-cycle pulse in the cycle after the request, and never both together. Either verdict clears the write-enable latch. Only a grant sets busy.
- R9: Busy stays high until a cycle-done pulse clears it. A cycle-done pulse while idle changes nothing.
- R10: While busy, all strobes are ignored: no verdict is given and the write-enable latch does not change.
- R11: When several strobes arrive together, only one request is judged, in the order status write, bulk erase, sector erase, page program. Any request takes precedence over a write-enable or write-disable strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| prog_req_i | input | 1 | Page program request strobe |
| sect_erase_req_i | input | 1 | Sector erase request strobe |
| bulk_erase_req_i | input | 1 | Bulk erase request strobe |
| sr_write_req_i | input | 1 | Status write request strobe |
| sr_wdata_i | input | 8 | Data byte for a status write |
| addr_i | input | 24 | Target address for program and sector erase |
| wp_n_i | input | 1 | Write-protect pin level, low asserts the lock |
| cycle_done_i | input | 1 | Pulse from the array engine ending a busy cycle |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Request accepted, one-cycle pulse |
| deny_o | output | 1 | Request refused, one-cycle pulse |
| busy_o | output | 1 | Cycle in progress |

## Verification
The hardest state to reach is one where the protect level is nonzero and has to be changed while the lock bit is also set. The only way in is a granted status write with the pin high, and the only way out is a second granted write, so the pin level has to be toggled between these two writes. The stimulus walks every protect level through the normal enable, write and cycle-done sequence. At each level it sweeps page program and sector erase across all 128 sectors, with the low address bits varied. It then sets the lock bit, lowers the pin, confirms that the byte is frozen, and raises the pin again to release it. Strobes sent during busy and simultaneous strobes are driven directly, and their effect is read back from the status byte.

// File: rtl/sr_pkg.sv
// Shared types for the status/protection guard.
// Assumes a status byte of eight bits with the field positions below.
package sr_pkg;
    typedef enum logic [2:0] {
        REQ_NONE = 3'd0,
        REQ_PROG = 3'd1,
        REQ_SECT = 3'd2,
        REQ_BULK = 3'd3,
        REQ_SRWR = 3'd4
    } req_e;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_WEL_BIT  = 1;
    localparam int STAT_LVL_LSB  = 2;
    localparam int STAT_LOCK_BIT = 7;
endpackage

// File: rtl/wp_range_decode.sv
// Decides whether an address falls in the region fenced by the protect level.
// Level 0 fences nothing, the top level fences all, level n fences the upper
// 2^(n-1) sectors. Assumes the sector number is the top SECTOR_W address bits.
module wp_range_decode #(
    parameter int ADDR_W   = 24,
    parameter int SECTOR_W = 7,
    parameter int LVL_W    = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic              hit_o
);
    localparam int LEVELS  = 1 << LVL_W;
    localparam int SECTORS = 1 << SECTOR_W;

    logic [SECTOR_W-1:0] sector;
    logic [LEVELS-1:0]   level_hit;

    // Sector index taken from the top of the address.
    assign sector = addr_i[ADDR_W-1 -: SECTOR_W];

    // One comparator per level; the level selects which one counts.
    for (genvar v = 0; v < LEVELS; v++) begin : g_level
        if (v == 0) begin : g_none
            assign level_hit[v] = 1'b0;
        end else if (v == LEVELS - 1 || (v - 1) >= SECTOR_W) begin : g_all
            assign level_hit[v] = 1'b1;
        end else begin : g_top
            localparam int FIRST = SECTORS - (1 << (v - 1));
            assign level_hit[v] = ({1'b0, sector} >= (SECTOR_W + 1)'(FIRST));
        end
    end

    assign hit_o = level_hit[level_i];
endmodule

// File: rtl/wp_request_judge.sv
// Picks one pending change request by fixed priority and decides whether it
// may proceed. Purely combinational; assumes status fields come from registers.
module wp_request_judge
    import sr_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             prog_req_i,
    input  logic             sect_req_i,
    input  logic             bulk_req_i,
    input  logic             srwr_req_i,
    input  logic             wel_i,
    input  logic             busy_i,
    input  logic             lock_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             wp_n_i,
    input  logic             range_hit_i,
    output req_e             kind_o,
    output logic             act_o,
    output logic             allow_o
);
    logic hw_locked;

    // Status write outranks bulk erase, which outranks sector erase, then program.
    always_comb begin
        kind_o = REQ_NONE;
        if (srwr_req_i)      kind_o = REQ_SRWR;
        else if (bulk_req_i) kind_o = REQ_BULK;
        else if (sect_req_i) kind_o = REQ_SECT;
        else if (prog_req_i) kind_o = REQ_PROG;
    end

    assign hw_locked = lock_i & ~wp_n_i;
    assign act_o     = (kind_o != REQ_NONE) & ~busy_i;

    // Permission per request kind; every kind needs the enable latch.
    always_comb begin
        unique case (kind_o)
            REQ_PROG, REQ_SECT: allow_o = wel_i & ~range_hit_i;
            REQ_BULK:           allow_o = wel_i & (level_i == '0);
            REQ_SRWR:           allow_o = wel_i & ~hw_locked;
            default:            allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sr_state_regs.sv
// Holds the status fields and the verdict pulses. Assumes the judge has
// already filtered requests arriving while busy (act_i low then).
module sr_state_regs
    import sr_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wren_i,
    input  logic             wrdi_i,
    input  logic             cycle_done_i,
    input  req_e             kind_i,
    input  logic             act_i,
    input  logic             allow_i,
    input  logic             new_lock_i,
    input  logic [LVL_W-1:0] new_level_i,
    output logic             lock_o,
    output logic [LVL_W-1:0] level_o,
    output logic             wel_o,
    output logic             busy_o,
    output logic             grant_o,
    output logic             deny_o
);
    // Status field and verdict update, one request per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_o  <= 1'b0;
            level_o <= '0;
            wel_o   <= 1'b0;
            busy_o  <= 1'b0;
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
        end else begin
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
            if (busy_o) begin
                if (cycle_done_i) busy_o <= 1'b0;
            end else if (act_i) begin
                wel_o <= 1'b0;
                if (allow_i) begin
                    grant_o <= 1'b1;
                    busy_o  <= 1'b1;
                    if (kind_i == REQ_SRWR) begin
                        lock_o  <= new_lock_i;
                        level_o <= new_level_i;
                    end
                end else begin
                    deny_o <= 1'b1;
                end
            end else if (wrdi_i) begin
                wel_o <= 1'b0;
            end else if (wren_i) begin
                wel_o <= 1'b1;
            end
        end
    end

    assert_verdict_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));
    assert_verdict_drops_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o || deny_o) |-> !wel_o);
    assert_busy_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> grant_o);
    assert_busy_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> (!grant_o && !deny_o));
    assert_fields_move_on_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_o |-> ($stable(lock_o) && $stable(level_o)));
endmodule

// File: rtl/flash_status_guard.sv
// Top of the status register and write-protection guard. Combines the range
// decode, the request judge and the state registers, and assembles the byte.
// Assumes strobes are single-cycle and come from an upstream command decoder.
module flash_status_guard
    import sr_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int SECTOR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              prog_req_i,
    input  logic              sect_erase_req_i,
    input  logic              bulk_erase_req_i,
    input  logic              sr_write_req_i,
    input  logic [7:0]        sr_wdata_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              deny_o,
    output logic              busy_o
);
    localparam int LVL_W = 3;

    logic             range_hit;
    logic             act;
    logic             allow;
    req_e             kind;
    logic             lock_q;
    logic [LVL_W-1:0] level_q;
    logic             wel_q;

    wp_range_decode #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .LVL_W(LVL_W)) u_range (
        .addr_i  (addr_i),
        .level_i (level_q),
        .hit_o   (range_hit)
    );

    wp_request_judge #(.LVL_W(LVL_W)) u_judge (
        .prog_req_i  (prog_req_i),
        .sect_req_i  (sect_erase_req_i),
        .bulk_req_i  (bulk_erase_req_i),
        .srwr_req_i  (sr_write_req_i),
        .wel_i       (wel_q),
        .busy_i      (busy_o),
        .lock_i      (lock_q),
        .level_i     (level_q),
        .wp_n_i      (wp_n_i),
        .range_hit_i (range_hit),
        .kind_o      (kind),
        .act_o       (act),
        .allow_o     (allow)
    );

    sr_state_regs #(.LVL_W(LVL_W)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .wren_i       (wren_i),
        .wrdi_i       (wrdi_i),
        .cycle_done_i (cycle_done_i),
        .kind_i       (kind),
        .act_i        (act),
        .allow_i      (allow),
        .new_lock_i   (sr_wdata_i[STAT_LOCK_BIT]),
        .new_level_i  (sr_wdata_i[STAT_LVL_LSB +: LVL_W]),
        .lock_o       (lock_q),
        .level_o      (level_q),
        .wel_o        (wel_q),
        .busy_o       (busy_o),
        .grant_o      (grant_o),
        .deny_o       (deny_o)
    );

    // Status byte assembly: lock, two zero bits, level, latch, busy.
    assign status_o = {lock_q, 2'b00, level_q, wel_q, busy_o};

    assert_hw_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_o[7] && !wp_n_i && sr_write_req_i && !busy_o) |-> deny_o);
    assert_bulk_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bulk_erase_req_i && !sr_write_req_i && !busy_o && (status_o[4:2] != 3'd0))
        |-> deny_o);
    assert_no_wel_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!status_o[1] && !busy_o && (prog_req_i || sect_erase_req_i ||
              bulk_erase_req_i || sr_write_req_i)) |-> deny_o);
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o && cycle_done_i) |-> !busy_o);
    assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b00);
endmodule

// File: tb/flash_status_guard_tb.sv
module flash_status_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OP_WREN = 0, OP_WRDI = 1, OP_PROG = 2, OP_SECT = 3,
                   OP_BULK = 4, OP_SRWR = 5, OP_DONE = 6, OP_IDLE = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren = 0, wrdi = 0, prog = 0, sect = 0, bulk = 0, srwr = 0;
    logic [7:0]  wdata = 8'h00;
    logic [23:0] addr = 24'h0;
    logic        wp_n = 1'b1;
    logic        done = 1'b0;
    logic [7:0]  status;
    logic        grant, deny, busy;
    int          total = 0;
    int          fails = 0;
    bit          finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_status_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdi_i(wrdi),
        .prog_req_i(prog), .sect_erase_req_i(sect), .bulk_erase_req_i(bulk),
        .sr_write_req_i(srwr), .sr_wdata_i(wdata), .addr_i(addr),
        .wp_n_i(wp_n), .cycle_done_i(done), .status_o(status),
        .grant_o(grant), .deny_o(deny), .busy_o(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one strobe from a falling edge; returns at the next falling edge,
    // where the registered reaction is visible.
    task automatic issue(input int op, input logic [7:0] d, input logic [23:0] a);
        wdata = d;
        addr  = a;
        case (op)
            OP_WREN: wren = 1;
            OP_WRDI: wrdi = 1;
            OP_PROG: prog = 1;
            OP_SECT: sect = 1;
            OP_BULK: bulk = 1;
            OP_SRWR: srwr = 1;
            OP_DONE: done = 1;
            default: ;
        endcase
        @(negedge clk);
        {wren, wrdi, prog, sect, bulk, srwr, done} = '0;
    endtask

    function automatic bit fenced(input int lvl, input int sec);
        if (lvl == 0) return 0;
        if (lvl == 7) return 1;
        return sec >= 128 - (1 << (lvl - 1));
    endfunction

    task automatic write_status(input logic [7:0] d);
        issue(OP_WREN, 8'h00, 24'h0);
        issue(OP_SRWR, d, 24'h0);
        chk("R6 status write granted", grant, 1);
        issue(OP_DONE, 8'h00, 24'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset verdicts", {grant, deny, busy}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", status, 8'h00);

        // R2: enable latch handling
        issue(OP_WREN, 8'h00, 24'h0);
        chk("R2 wren sets bit1", status, 8'h02);
        issue(OP_WRDI, 8'h00, 24'h0);
        chk("R2 wrdi clears bit1", status, 8'h00);
        wren = 1;
        issue(OP_WRDI, 8'h00, 24'h0);
        chk("R2 wrdi wins over wren", status, 8'h00);

        // R3: no latch -> deny
        issue(OP_PROG, 8'h00, 24'h000100);
        chk("R3 program without latch denied", {grant, deny}, 2'b01);
        issue(OP_SRWR, 8'h1C, 24'h0);
        chk("R3 status write without latch denied", {grant, deny}, 2'b01);
        chk("R3 status unchanged", status, 8'h00);

        // R9: done while idle is ignored
        issue(OP_DONE, 8'h00, 24'h0);
        chk("R9 idle done no effect", {status, grant, deny}, {8'h00, 2'b00});

        // R4/R5/R8: sweep every level over every sector
        for (int lvl = 0; lvl < 8; lvl++) begin
            write_status(8'(lvl << 2));
            chk("R7 level loaded", status, 8'(lvl << 2));
            for (int s = 0; s < 128; s++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [23:0] a;
                    bit ok;
                    a = {7'(s), 17'(s * 1031 + k * 77)};
                    ok = !fenced(lvl, s);
                    issue(OP_WREN, 8'h00, 24'h0);
                    issue(k == 0 ? OP_PROG : OP_SECT, 8'h00, a);
                    chk("R4 verdict by sector", {grant, deny}, {ok, !ok});
                    chk("R8 latch consumed, busy on grant", {status[1], busy}, {1'b0, ok});
                    if (ok) begin
                        issue(OP_DONE, 8'h00, 24'h0);
                        chk("R9 done clears busy", busy, 0);
                    end
                end
            end
            issue(OP_WREN, 8'h00, 24'h0);
            issue(OP_BULK, 8'h00, 24'h0);
            chk("R5 bulk erase by level", {grant, deny}, {lvl == 0, lvl != 0});
            if (lvl == 0) issue(OP_DONE, 8'h00, 24'h0);
        end

        // R7: only bits 7 and 4:2 are taken
        write_status(8'h00);
        issue(OP_WREN, 8'h00, 24'h0);
        issue(OP_SRWR, 8'h63, 24'h0);
        chk("R7 ignored data bits", status, 8'h01);
        issue(OP_DONE, 8'h00, 24'h0);
        issue(OP_WREN, 8'h00, 24'h0);
        issue(OP_SRWR, 8'hFF, 24'h0);
        chk("R7 lock and level loaded", status, 8'h9D);
        issue(OP_DONE, 8'h00, 24'h0);

        // R6: lock bit plus low pin freezes the byte
        wp_n = 1'b0;
        issue(OP_WREN, 8'h00, 24'h0);
        issue(OP_SRWR, 8'h00, 24'h0);
        chk("R6 locked write denied", {grant, deny}, 2'b01);
        chk("R6 byte frozen", status, 8'h9C);
        wp_n = 1'b1;
        issue(OP_WREN, 8'h00, 24'h0);
        issue(OP_SRWR, 8'h84, 24'h0);
        chk("R6 pin high releases", {grant, deny, status}, {2'b10, 8'h85});
        issue(OP_DONE, 8'h00, 24'h0);
        wp_n = 1'b0;
        issue(OP_WREN, 8'h00, 24'h0);
        issue(OP_SRWR, 8'h00, 24'h0);
        chk("R6 lock held at level 1", status, 8'h84);
        wp_n = 1'b1;
        write_status(8'h04);
        chk("R6 lock cleared", status, 8'h04);

        // R11: simultaneous requests, level 1 fences sector 127
        issue(OP_WREN, 8'h00, 24'h0);
        prog = 1;
        issue(OP_SRWR, 8'h08, 24'hFE0000);
        chk("R11 status write beats program", {grant, status}, {1'b1, 8'h09});
        issue(OP_DONE, 8'h00, 24'h0);
        write_status(8'h04);
        issue(OP_WREN, 8'h00, 24'h0);
        sect = 1;
        issue(OP_BULK, 8'h00, 24'h000000);
        chk("R11 bulk beats sector", {grant, deny}, 2'b01);
        issue(OP_WREN, 8'h00, 24'h0);
        wrdi = 1;
        issue(OP_SECT, 8'h00, 24'h010000);
        chk("R11 request beats wrdi", {grant, deny}, 2'b10);

        // R10: strobes ignored while busy
        issue(OP_WREN, 8'h00, 24'h0);
        chk("R10 wren ignored while busy", status, 8'h05);
        issue(OP_PROG, 8'h00, 24'h000000);
        chk("R10 no verdict while busy", {grant, deny}, 2'b00);
        issue(OP_SRWR, 8'h00, 24'h0);
        chk("R10 status write ignored while busy", {grant, deny, status}, {2'b00, 8'h05});
        issue(OP_DONE, 8'h00, 24'h0);
        chk("R9 done ends busy", status, 8'h04);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule